// File: doc/BRIEF.md
# Serial Configuration Bitstream Streamer

This block is the read-out half of a serial configuration memory. A programmable device that loads itself in master serial mode drives the clock. On every rising edge of that clock the block presents the next configuration bit on its data output. An address counter selects a word of the memory array, and a bit counter inside it picks the bit that goes out. A stand-in read-only model provides the array contents. The programming path is not part of this block.

The block has three control inputs.
- A single input acts as both reset and output enable. When it is low, the counters return to the first bit and the data driver turns off.
- An active-low chip enable gates counting and shows standby when it is high.
- A serial-enable input, when low, puts the device in programming mode. In that mode the read-out path stays silent.

When the last configured bit has gone out, the device stops driving and pulls its cascade output low. That output can drive the chip enable of a second memory on the same data line, so several memories chain into one stream. The output is a data value plus an active-high drive enable. A pad outside the block makes these into a tri-state pin.

Top module: `cfg_stream_top`

## Requirements
- R1: While `rst_oe` is low, `dout_en` is 0 in that same cycle, whatever `ce_n` is. A rising clock edge with `rst_oe` low returns the position to bit 0 of word 0 and sets `cascade_n` to 1.
- R2: In the active state, `dout_en` is 1. The active state is `ser_en`=1, `rst_oe`=1, `ce_n`=0, and the end of data not reached. In that state each rising edge advances the position by exactly one bit.
- R3: With `ser_en`=1 and `ce_n`=1, `standby` is 1, `dout_en` is 0, and clock edges leave the position unchanged.
- R4: After TOTAL_BITS counting edges, `cascade_n` is 0 and `dout_en` is 0. Further edges do not move the position.
- R5: Once low, `cascade_n` stays low through any `ce_n` or `ser_en` activity. It returns to 1 only after a clock edge with `rst_oe` low, or after `por_n` goes low.
- R6: `por_n` low clears the position to bit 0 of word 0 at once and sets `cascade_n` to 1. No `rst_oe` pulse is needed.
- R7: With `ser_en`=0, `dout_en` and `standby` are both 0. `ce_n` has no effect, and the position holds unless `rst_oe` is low.
- R8: Chip enable is sampled only at the rising edge. A low pulse on `ce_n` that ends before the next edge advances nothing.
- R9: Bit k of the stream is found as follows: take the word at address k / WORD_W, then take bit number WORD_W-1-(k mod WORD_W) of that word. Bits therefore leave each word most-significant first. The word at address a is the low WORD_W bits of 37*a+11. When TOTAL_BITS is not a multiple of WORD_W, the stream ends partway through the last word.
- R10: When two blocks share one data line, the first block's `cascade_n` drives the second block's `ce_n`. The two `dout_en` outputs are never 1 together, and the second block starts at its bit 0 on the cycle after the first block's last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock, rising edge counts |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ser_en | input | 1 | 1 = read-out mode, 0 = programming mode |
| rst_oe | input | 1 | Low: clear position and disable output; high: output enable |
| ce_n | input | 1 | Chip enable, active low |
| dout | output | 1 | Current configuration bit (0 when not driven) |
| dout_en | output | 1 | Data driver enable, active high |
| cascade_n | output | 1 | Low once all bits have been sent |
| standby | output | 1 | High when chip enable is inactive in read-out mode |

## Verification
`dout_en` and `standby` are combinational in the control inputs and the stored state, so they are due in the same cycle as any input change. The position, and with it `dout` and `cascade_n`, changes only at a rising edge, so a new bit appears one edge after a counting cycle. The bench changes inputs 5 ns after each rising edge and compares all outputs a few nanoseconds later, within the same cycle. Its reference model advances only on the edge that follows, using the inputs that were held before that edge. This is also how the short `ce_n` pulse is shown to be ignored.

// File: rtl/cfg_stream_pkg.sv
`timescale 1ns/1ps
package cfg_stream_pkg;

   // Stand-in array contents: word at address a is 37*a + 11 (truncated by user)
   function automatic logic [31:0] pattern_word(input logic [31:0] a);
      return a * 32'd37 + 32'd11;
   endfunction

endpackage

// File: rtl/cfg_pos_counter.sv
`timescale 1ns/1ps
module cfg_pos_counter #(
   parameter int WORD_W     = 8,
   parameter int TOTAL_BITS = 226520,
   parameter int ADDR_W     = 15,
   parameter int BIT_W      = 3
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              clear,
   input  logic              step,
   output logic [ADDR_W-1:0] addr_q,
   output logic [BIT_W-1:0]  bit_q,
   output logic              done_q
);
   localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'((TOTAL_BITS - 1) / WORD_W);
   localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'((TOTAL_BITS - 1) % WORD_W);
   localparam logic [BIT_W-1:0]  WRAP_BIT  = BIT_W'(WORD_W - 1);

   logic at_end;
   assign at_end = (addr_q == LAST_ADDR) && (bit_q == LAST_BIT);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         addr_q <= '0;
         bit_q  <= '0;
         done_q <= 1'b0;
      end else if (clear) begin
         addr_q <= '0;
         bit_q  <= '0;
         done_q <= 1'b0;
      end else if (step && !done_q) begin
         if (at_end) begin
            done_q <= 1'b1;
         end else if (bit_q == WRAP_BIT) begin
            bit_q  <= '0;
            addr_q <= addr_q + ADDR_W'(1);
         end else begin
            bit_q  <= bit_q + BIT_W'(1);
         end
      end
   end
endmodule

// File: rtl/cfg_rom_model.sv
`timescale 1ns/1ps
module cfg_rom_model #(
   parameter int WORD_W = 8,
   parameter int ADDR_W = 15
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [WORD_W-1:0] word
);
   import cfg_stream_pkg::*;

   always_comb begin
      word = WORD_W'(pattern_word(32'(addr)));
   end
endmodule

// File: rtl/cfg_bit_select.sv
`timescale 1ns/1ps
module cfg_bit_select #(
   parameter int WORD_W    = 8,
   parameter int BIT_W     = 3,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic [WORD_W-1:0] word,
   input  logic [BIT_W-1:0]  bit_idx,
   output logic              bit_o
);
   localparam logic [BIT_W-1:0] TOP_IDX = BIT_W'(WORD_W - 1);

   generate
      if (MSB_FIRST) begin : g_msb
         assign bit_o = word[TOP_IDX - bit_idx];
      end else begin : g_lsb
         assign bit_o = word[bit_idx];
      end
   endgenerate
endmodule

// File: rtl/cfg_stream_top.sv
`timescale 1ns/1ps
module cfg_stream_top #(
   parameter int WORD_W     = 8,
   parameter int TOTAL_BITS = 226520,
   parameter bit MSB_FIRST  = 1'b1
) (
   input  logic clk,
   input  logic por_n,
   input  logic ser_en,
   input  logic rst_oe,
   input  logic ce_n,
   output logic dout,
   output logic dout_en,
   output logic cascade_n,
   output logic standby
);
   localparam int NUM_WORDS = (TOTAL_BITS + WORD_W - 1) / WORD_W;
   localparam int ADDR_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
   localparam int BIT_W     = (WORD_W > 1) ? $clog2(WORD_W) : 1;

   generate
      if (WORD_W < 1 || WORD_W > 32) begin : g_bad_word
         $error("cfg_stream_top: WORD_W must be 1..32");
      end
      if (TOTAL_BITS < 1) begin : g_bad_len
         $error("cfg_stream_top: TOTAL_BITS must be at least 1");
      end
   endgenerate

   logic [ADDR_W-1:0] addr_q;
   logic [BIT_W-1:0]  bit_q;
   logic              done_q;
   logic [WORD_W-1:0] cur_word;
   logic              cur_bit;
   logic              count_ok;

   // Counting and driving need read-out mode, output enable and chip enable
   assign count_ok = ser_en & rst_oe & ~ce_n;

   cfg_pos_counter #(
      .WORD_W(WORD_W), .TOTAL_BITS(TOTAL_BITS), .ADDR_W(ADDR_W), .BIT_W(BIT_W)
   ) u_pos (
      .clk(clk), .por_n(por_n), .clear(~rst_oe), .step(count_ok),
      .addr_q(addr_q), .bit_q(bit_q), .done_q(done_q)
   );

   cfg_rom_model #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_rom (
      .addr(addr_q), .word(cur_word)
   );

   cfg_bit_select #(.WORD_W(WORD_W), .BIT_W(BIT_W), .MSB_FIRST(MSB_FIRST)) u_sel (
      .word(cur_word), .bit_idx(bit_q), .bit_o(cur_bit)
   );

   assign dout_en   = count_ok & ~done_q;
   assign dout      = cur_bit & dout_en;
   assign cascade_n = ~done_q;
   assign standby   = ser_en & ce_n;
endmodule

// File: rtl/cfg_stream_chk.sv
`timescale 1ns/1ps
module cfg_stream_chk #(
   parameter int ADDR_W = 15,
   parameter int BIT_W  = 3
) (
   input logic              clk,
   input logic              por_n,
   input logic              ser_en,
   input logic              rst_oe,
   input logic              ce_n,
   input logic              dout_en,
   input logic              cascade_n,
   input logic              standby,
   input logic [ADDR_W-1:0] addr_q,
   input logic [BIT_W-1:0]  bit_q
);
   p_hiz_r1: assert property (@(posedge clk) disable iff (!por_n)
      !rst_oe |-> !dout_en);

   p_clear_r1: assert property (@(posedge clk) disable iff (!por_n)
      !rst_oe |=> (addr_q == '0 && bit_q == '0 && cascade_n));

   p_advance_r2: assert property (@(posedge clk) disable iff (!por_n)
      (ser_en && rst_oe && !ce_n && cascade_n) |=> (!$stable({addr_q, bit_q}) || !cascade_n));

   p_standby_r3: assert property (@(posedge clk) disable iff (!por_n)
      (ser_en && ce_n) |-> (standby && !dout_en));

   p_freeze_r3: assert property (@(posedge clk) disable iff (!por_n)
      (rst_oe && ce_n) |=> $stable({addr_q, bit_q}));

   p_end_quiet_r4: assert property (@(posedge clk) disable iff (!por_n)
      !cascade_n |-> !dout_en);

   p_sticky_r5: assert property (@(posedge clk) disable iff (!por_n)
      (!cascade_n && rst_oe) |=> !cascade_n);

   p_prog_quiet_r7: assert property (@(posedge clk) disable iff (!por_n)
      !ser_en |-> (!dout_en && !standby));

   p_prog_hold_r7: assert property (@(posedge clk) disable iff (!por_n)
      (!ser_en && rst_oe) |=> $stable({addr_q, bit_q}));
endmodule

bind cfg_stream_top cfg_stream_chk #(.ADDR_W(ADDR_W), .BIT_W(BIT_W)) u_chk (
   .clk(clk), .por_n(por_n), .ser_en(ser_en), .rst_oe(rst_oe), .ce_n(ce_n),
   .dout_en(dout_en), .cascade_n(cascade_n), .standby(standby),
   .addr_q(addr_q), .bit_q(bit_q)
);

// File: tb/tb_cfg_stream_top.sv
`timescale 1ns/1ps
module tb_cfg_stream_top;
   localparam int T  = 44;   // 5.5 words: ends mid-word
   localparam int WW = 8;

   logic clk = 1'b0;
   logic por_n, ser_en, rst_oe, ce_n;
   logic dout_a, en_a, casc_a, stby_a;
   logic dout_b, en_b, casc_b, stby_b;

   int checks = 0;
   int errors = 0;
   int pos_a = 0;
   int pos_b = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   cfg_stream_top #(.WORD_W(WW), .TOTAL_BITS(T)) dut (
      .clk(clk), .por_n(por_n), .ser_en(ser_en), .rst_oe(rst_oe), .ce_n(ce_n),
      .dout(dout_a), .dout_en(en_a), .cascade_n(casc_a), .standby(stby_a)
   );

   cfg_stream_top #(.WORD_W(WW), .TOTAL_BITS(T)) dut_nx (
      .clk(clk), .por_n(por_n), .ser_en(ser_en), .rst_oe(rst_oe), .ce_n(casc_a),
      .dout(dout_b), .dout_en(en_b), .cascade_n(casc_b), .standby(stby_b)
   );

   function automatic logic exp_bit(input int k);
      logic [7:0] w;
      w = 8'((k / WW) * 37 + 11);
      return w[WW - 1 - (k % WW)];
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   // Compare both devices against the model in the current cycle
   task automatic check_all(input string tag);
      logic ca, cb, ea, eb;
      ca = (pos_a < T);
      cb = (pos_b < T);
      ea = ser_en & rst_oe & ~ce_n & ca;
      eb = ser_en & rst_oe & ~ca & cb;
      chk({tag, " en_a"}, 32'(en_a), 32'(ea));
      chk({tag, " casc_a"}, 32'(casc_a), 32'(ca));
      chk({tag, " stby_a"}, 32'(stby_a), 32'(ser_en & ce_n));
      if (ea) chk({tag, " R9 dout_a"}, 32'(dout_a), 32'(exp_bit(pos_a)));
      chk({tag, " en_b"}, 32'(en_b), 32'(eb));
      chk({tag, " casc_b"}, 32'(casc_b), 32'(cb));
      if (eb) chk({tag, " R9 dout_b"}, 32'(dout_b), 32'(exp_bit(pos_b)));
      chk("R10 single driver", 32'(en_a & en_b), 32'd0);
   endtask

   // Advance model with inputs held before the edge, then settle past the edge
   task automatic tick();
      logic ca;
      ca = (pos_a < T);
      @(posedge clk);
      if (!por_n || !rst_oe) begin
         pos_a = 0;
         pos_b = 0;
      end else begin
         if (ser_en && !ce_n && pos_a < T) pos_a++;
         if (ser_en && !ca && pos_b < T) pos_b++;
      end
      #5;
   endtask

   initial begin
      #(20 * 200000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual=hung expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      por_n = 1'b0; ser_en = 1'b1; rst_oe = 1'b1; ce_n = 1'b0;
      tick(); tick();
      por_n = 1'b1; #2;
      // R6: reset state without any rst_oe pulse
      chk("R6 cascade after por", 32'(casc_a), 32'd1);
      chk("R6 first bit", 32'(dout_a), 32'(exp_bit(0)));
      check_all("R6");

      // R2/R9: stream 20 bits (crosses two word boundaries)
      for (int i = 0; i < 20; i++) begin
         tick();
         check_all("R2");
      end
      chk("R2 position after 20", 32'(pos_a), 32'd20);

      // R1: abort partway, ce_n high too
      rst_oe = 1'b0; ce_n = 1'b1; #2;
      chk("R1 driver off immediately", 32'(en_a), 32'd0);
      tick();
      rst_oe = 1'b1; ce_n = 1'b0; #2;
      chk("R1 restart at bit 0", 32'(dout_a), 32'(exp_bit(0)));
      chk("R1 enabled after restart", 32'(en_a), 32'd1);
      for (int i = 0; i < 3; i++) begin tick(); check_all("R1"); end

      // R3: standby freezes
      ce_n = 1'b1; #2;
      chk("R3 standby", 32'(stby_a), 32'd1);
      for (int i = 0; i < 4; i++) begin tick(); check_all("R3"); end
      chk("R3 frozen position", 32'(pos_a), 32'd3);

      // R8: short ce_n low pulse between edges is not sampled
      ce_n = 1'b0; #5; ce_n = 1'b1;
      tick();
      ce_n = 1'b0; #2;
      chk("R8 no advance from pulse", 32'(dout_a), 32'(exp_bit(3)));
      check_all("R8");

      // R7: programming mode
      ser_en = 1'b0; #2;
      chk("R7 driver off", 32'(en_a), 32'd0);
      chk("R7 no standby", 32'(stby_a), 32'd0);
      for (int i = 0; i < 3; i++) begin tick(); check_all("R7"); end
      ser_en = 1'b1; #2;
      chk("R7 position held", 32'(dout_a), 32'(exp_bit(3)));

      // R4/R10: run through the first device and hand over to the second
      while (pos_a < T) begin tick(); check_all("R4"); end
      chk("R4 cascade low", 32'(casc_a), 32'd0);
      chk("R4 first driver off", 32'(en_a), 32'd0);
      chk("R10 second starts at bit 0", 32'(dout_b), 32'(exp_bit(0)));
      chk("R10 second enabled", 32'(en_b), 32'd1);
      while (pos_b < T) begin tick(); check_all("R10"); end
      tick(); check_all("R4");
      chk("R4 line idle", 32'(en_a | en_b), 32'd0);

      // R5: cascade sticky through ce_n/ser_en activity, cleared by rst_oe
      ce_n = 1'b1; tick(); ser_en = 1'b0; tick(); ser_en = 1'b1; ce_n = 1'b0; tick();
      chk("R5 cascade sticky", 32'(casc_a), 32'd0);
      rst_oe = 1'b0; tick(); rst_oe = 1'b1; #2;
      chk("R5 cascade released", 32'(casc_a), 32'd1);
      check_all("R5");

      // R6: asynchronous power-on reset mid-stream
      for (int i = 0; i < 9; i++) tick();
      #3; por_n = 1'b0; pos_a = 0; pos_b = 0; #2;
      chk("R6 async clear", 32'(casc_a), 32'd1);
      tick(); por_n = 1'b1; #2;
      chk("R6 bit 0 after por", 32'(dout_a), 32'(exp_bit(0)));

      // Random mix
      for (int i = 0; i < 900; i++) begin
         rst_oe = ($urandom_range(0, 15) != 0);
         ce_n   = ($urandom_range(0, 7) == 0);
         ser_en = ($urandom_range(0, 15) != 0);
         #2;
         check_all("R2 random");
         tick();
      end

      finished = 1'b1;
      summary();
      $finish;
   end
endmodule